// File: doc/BRIEF.md
# Ping-Pong Frame Packetizer

The packetizer takes captured frame records out of a per-channel staging RAM and copies them, one 32-bit word per cycle, into one of two external record buffers. A record is a three-word metadata header (two timestamp words, then a status word at word index 2) followed by the frame words. One buffer is filled while the other is held by a DMA engine. Records are placed whole: before a record is copied, its length is compared with the space left. A record that does not fit is held back, the buffers change roles, and the record becomes the first one in the other buffer.

A buffer is handed over when it is exactly full, when the next record would overflow it, or when a latency timer expires. The timer counts 10 MHz ticks from the first word written into an empty buffer, and the threshold is a parameter. Each hand-over raises a one-cycle ready event carrying the buffer index and its word count. If the buffer needs to change for lack of space while the other buffer is still held by DMA, reads from the staging RAM stall and no record is lost. Once DMA releases the held buffer, the swap proceeds and the overrun bit is set in the status word of the first record written after the swap.

The staging side presents the head record's length and a valid flag. It returns data one cycle after each read strobe and advances to the next record after the last word of a record has been read. Records are at least three words and never longer than a buffer.

Top module: `pp_packetizer`

## Requirements
- R1: The two buffers alternate. Ready events carry index 0, then 1, then 0 and so on. No word is ever written into a buffer that has been reported ready and not yet released by `dma_done`.
- R2: A record is written contiguously, starting at the current fill level, whenever fill plus length is at most `BUF_WORDS`. This includes a record that lands exactly on the last word. Each word read from staging is written in the cycle after its read strobe.
- R3: A record that would exceed the buffer, even by one word, is not split. The buffer is handed over with its current count, and the record starts at address 0 of the other buffer.
- R4: A buffer whose fill reaches `BUF_WORDS` is handed over with a count equal to `BUF_WORDS`.
- R5: A non-empty buffer is handed over once `TIMER_LIMIT` ticks have been counted since the first word was written into it while it was empty. It is not handed over after fewer ticks. Expiry takes effect between records, and the timer restarts on every swap.
- R6: An empty buffer is never handed over, whatever the number of ticks, and no ready event ever reports a count of 0.
- R7: The ready event (`rdy_valid`) is high for exactly one cycle per hand-over, with `rdy_idx` and `rdy_count` valid in that cycle.
- R8: If a full or no-fit condition needs a swap while the other buffer is still held, `rd_en` stays low and nothing is written until `dma_done`. After the swap, bit 29 of word index 2 of the first record in the new buffer is set. Later records are written unmarked.
- R9: A `dma_done` in the very cycle the swap is needed counts as in time. The swap happens in that cycle and no overrun bit is set.
- R10: During reset, `rd_en`, `wr_en` and `rdy_valid` are low, and buffer 0 is filled first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rec_valid | input | 1 | Staging RAM holds at least one record |
| rec_words | input | CW | Total words of the head record, metadata included |
| rd_en | output | 1 | Read strobe to the staging RAM |
| rd_data | input | 32 | Staging word, valid one cycle after `rd_en` |
| tick | input | 1 | 10 MHz time tick, one-cycle pulse |
| dma_done | input | 1 | DMA has released the buffer handed to it |
| wr_en | output | 1 | Buffer write strobe |
| wr_sel | output | 1 | Buffer written (0 or 1) |
| wr_addr | output | AW | Word address inside the selected buffer |
| wr_data | output | 32 | Word written |
| rdy_valid | output | 1 | One-cycle buffer-ready event |
| rdy_idx | output | 1 | Index of the buffer handed over |
| rdy_count | output | CW | Number of words in that buffer |

## Verification
The DMA release and a capacity-driven swap can land in the same cycle. The bench sets this up by filling the active buffer to its last address while the other buffer is still held. It watches for the write to that address and drives `dma_done` high only in the following cycle, which is the cycle the swap is decided. The outcome is judged at the ports: the next ready event must report a full buffer, and the status word of the next record must have bit 29 clear. A design that saw the release one cycle late would stall and mark that record as an overrun. The complementary case, a release that arrives late, must set that bit and keep `rd_en` low for the whole wait.

// File: rtl/pp_pkg.sv
// Shared types and constants of the ping-pong frame packetizer.
// Assumes records carry their status word at word index 2.
package pp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_COPY = 2'd1,
        ST_TAIL = 2'd2
    } pp_state_e;

    localparam int STATUS_IDX = 2;
    localparam int OVR_BIT    = 29;

endpackage

// File: rtl/pp_flush_timer.sv
// Latency timer: counts ticks from the first word in an empty buffer.
// Assumes start and clear never coincide (clear happens only in idle).
module pp_flush_timer #(
    parameter int LIMIT = 900000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic clear,
    input  logic tick,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LIM = TW'(LIMIT);

    logic          running;
    logic [TW-1:0] ticks;

    // Arm on first word, count ticks while armed, saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            running <= 1'b0;
            ticks   <= '0;
        end else begin
            if (start) begin
                running <= 1'b1;
            end
            if (running && tick && (ticks != LIM)) begin
                ticks <= ticks + 1'b1;
            end
        end
    end

    assign expired = running && (ticks == LIM);

endmodule

// File: rtl/pp_buf_owner.sv
// Buffer ownership: which buffer is filled, whether the other is held by
// DMA, and whether the next record must carry the overrun mark.
// Assumes swap is only requested when other_free is high.
module pp_buf_owner (
    input  logic clk,
    input  logic rst_n,
    input  logic swap,
    input  logic dma_done,
    input  logic cap_block,
    input  logic rec_end,
    output logic act,
    output logic other_free,
    output logic ovr_mark
);
    logic busy;
    logic ovr_pend;

    // A release in the current cycle frees the other buffer at once.
    assign other_free = !busy || dma_done;

    // Track ownership, the pending overrun and the mark for the next record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act      <= 1'b0;
            busy     <= 1'b0;
            ovr_pend <= 1'b0;
            ovr_mark <= 1'b0;
        end else if (swap) begin
            act      <= ~act;
            busy     <= 1'b1;
            ovr_mark <= ovr_pend;
            ovr_pend <= 1'b0;
        end else begin
            if (dma_done) begin
                busy <= 1'b0;
            end
            if (cap_block) begin
                ovr_pend <= 1'b1;
            end
            if (rec_end) begin
                ovr_mark <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pp_packetizer.sv
// Ping-pong frame packetizer top. Copies whole records from staging into
// the active buffer, swaps on full, no-fit or timer expiry, and stalls
// with an overrun mark when the other buffer is still held by DMA.
// Assumes 3 <= rec_words <= BUF_WORDS and staging data one cycle after rd_en.
module pp_packetizer
    import pp_pkg::*;
#(
    parameter int BUF_WORDS   = 131072,
    parameter int TIMER_LIMIT = 900000,
    parameter int DW          = 32,
    localparam int AW = $clog2(BUF_WORDS),
    localparam int CW = $clog2(BUF_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rec_valid,
    input  logic [CW-1:0] rec_words,
    output logic          rd_en,
    input  logic [DW-1:0] rd_data,
    input  logic          tick,
    input  logic          dma_done,
    output logic          wr_en,
    output logic          wr_sel,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          rdy_valid,
    output logic          rdy_idx,
    output logic [CW-1:0] rdy_count
);
    localparam logic [CW:0]   CAP_X    = (CW + 1)'(BUF_WORDS);
    localparam logic [CW-1:0] CAP      = CW'(BUF_WORDS);
    localparam logic [CW-1:0] STAT_POS = CW'(STATUS_IDX);
    localparam logic [DW-1:0] OVR_MASK = DW'(1) << OVR_BIT;

    pp_state_e     state;
    logic [CW-1:0] fill;
    logic [CW-1:0] rem;
    logic [CW-1:0] widx;
    logic [CW-1:0] widx_q;
    logic          rd_q;
    logic          act;
    logic          other_free;
    logic          ovr_mark;
    logic          expired;
    logic          in_idle;
    logic          fits;
    logic          need_cap;
    logic          need_tmr;
    logic          want_swap;
    logic          swap;
    logic          cap_block;
    logic          start_rec;

    // Decide between swapping, starting a record and waiting.
    always_comb begin
        in_idle   = (state == ST_IDLE);
        fits      = ({1'b0, fill} + {1'b0, rec_words}) <= CAP_X;
        need_cap  = (fill != '0) && ((fill == CAP) || (rec_valid && !fits));
        need_tmr  = (fill != '0) && expired;
        want_swap = in_idle && (need_cap || need_tmr);
        swap      = want_swap && other_free;
        cap_block = in_idle && need_cap && !other_free;
        start_rec = in_idle && !want_swap && rec_valid;
    end

    // Record copy sequencer: one read per cycle, then one cycle for the tail write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            rem   <= '0;
            widx  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_rec) begin
                        rem   <= rec_words;
                        widx  <= '0;
                        state <= ST_COPY;
                    end
                end
                ST_COPY: begin
                    rem  <= rem - 1'b1;
                    widx <= widx + 1'b1;
                    if (rem == CW'(1)) begin
                        state <= ST_TAIL;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Align the write with the returning staging data and count the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            widx_q <= '0;
            fill   <= '0;
        end else begin
            rd_q   <= rd_en;
            widx_q <= widx;
            if (swap) begin
                fill <= '0;
            end else if (rd_q) begin
                fill <= fill + 1'b1;
            end
        end
    end

    // Register the one-cycle buffer-ready event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_valid <= 1'b0;
            rdy_idx   <= 1'b0;
            rdy_count <= '0;
        end else begin
            rdy_valid <= swap;
            if (swap) begin
                rdy_idx   <= act;
                rdy_count <= fill;
            end
        end
    end

    assign rd_en   = (state == ST_COPY);
    assign wr_en   = rd_q;
    assign wr_sel  = act;
    assign wr_addr = fill[AW-1:0];
    assign wr_data = (ovr_mark && (widx_q == STAT_POS)) ? (rd_data | OVR_MASK) : rd_data;

    pp_flush_timer #(
        .LIMIT (TIMER_LIMIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (rd_q && (fill == '0)),
        .clear   (swap),
        .tick    (tick),
        .expired (expired)
    );

    pp_buf_owner u_owner (
        .clk        (clk),
        .rst_n      (rst_n),
        .swap       (swap),
        .dma_done   (dma_done),
        .cap_block  (cap_block),
        .rec_end    (state == ST_TAIL),
        .act        (act),
        .other_free (other_free),
        .ovr_mark   (ovr_mark)
    );

endmodule

// File: rtl/pp_packetizer_chk.sv
// Port-level checker for pp_packetizer: tracks the buffer held by DMA from
// the ready events and releases, and checks ordering and event rules.
module pp_packetizer_chk #(
    parameter int BUF_WORDS = 131072,
    localparam int CW = $clog2(BUF_WORDS + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_en,
    input logic          wr_en,
    input logic          wr_sel,
    input logic          dma_done,
    input logic          rdy_valid,
    input logic          rdy_idx,
    input logic [CW-1:0] rdy_count
);
    logic drain_busy;
    logic drain_idx;
    logic seen;
    logic last_idx;

    // Follow which buffer DMA holds and the index of the last event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drain_busy <= 1'b0;
            drain_idx  <= 1'b0;
            seen       <= 1'b0;
            last_idx   <= 1'b0;
        end else begin
            drain_busy <= (drain_busy || rdy_valid) && !dma_done;
            if (rdy_valid) begin
                drain_idx <= rdy_idx;
                seen      <= 1'b1;
                last_idx  <= rdy_idx;
            end
        end
    end

    AST_NO_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && drain_busy) |-> (wr_sel != drain_idx)); // R1
    AST_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_valid && seen) |-> (rdy_idx != last_idx)); // R1
    AST_READ_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> wr_en); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_valid |-> (rdy_count <= CW'(BUF_WORDS))); // R4
    AST_NO_EMPTY_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_valid |-> (rdy_count != '0)); // R6
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_valid |=> !rdy_valid); // R7

endmodule

bind pp_packetizer pp_packetizer_chk #(
    .BUF_WORDS (BUF_WORDS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .dma_done  (dma_done),
    .rdy_valid (rdy_valid),
    .rdy_idx   (rdy_idx),
    .rdy_count (rdy_count)
);

// File: tb/tb_pp_packetizer.sv
// Bench for pp_packetizer with small buffers and a short timer.
module tb_pp_packetizer;
    localparam int BW = 16;
    localparam int TL = 5;
    localparam int CW = $clog2(BW + 1);
    localparam int AW = $clog2(BW);
    localparam logic [31:0] OVR = 32'h2000_0000;

    // Table entry: [15:8] record length, [7] expected buffer, [4:0] expected start address.
    localparam logic [15:0] TBL [7] = '{16'h0500, 16'h0605, 16'h050B, 16'h0480,
                                        16'h0C84, 16'h0700, 16'h0A80};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rec_valid;
    logic [CW-1:0] rec_words;
    logic          rd_en;
    logic [31:0]   rd_data;
    logic          tick = 1'b0;
    logic          dma_done = 1'b0;
    logic          wr_en;
    logic          wr_sel;
    logic [AW-1:0] wr_addr;
    logic [31:0]   wr_data;
    logic          rdy_valid;
    logic          rdy_idx;
    logic [CW-1:0] rdy_count;

    int n_chk = 0;
    int n_err = 0;
    int n_push = 0;
    int rec_len [32];
    int head = 0;
    int off = 0;
    logic [31:0] bufm [2][BW];
    int first_sel [32];
    int first_addr [32];
    int ev_idx [16];
    int ev_cnt [16];
    int n_ev = 0;
    int hi_cycles = 0;
    int rd_cycles = 0;
    logic rel_pend = 1'b0;

    always #4 clk = ~clk;

    pp_packetizer #(.BUF_WORDS(BW), .TIMER_LIMIT(TL)) dut (
        .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_words(rec_words),
        .rd_en(rd_en), .rd_data(rd_data), .tick(tick), .dma_done(dma_done),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .rdy_valid(rdy_valid), .rdy_idx(rdy_idx), .rdy_count(rdy_count)
    );

    // Staging RAM model: word = {8'h5A, record number, offset}.
    assign rec_valid = head < n_push;
    assign rec_words = CW'(rec_len[head]);
    always @(posedge clk) begin
        if (!rst_n) begin
            head <= 0; off <= 0; rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= {8'h5A, 8'(head), 16'(off)};
            if (off + 1 == rec_len[head]) begin
                head <= head + 1; off <= 0;
            end else begin
                off <= off + 1;
            end
        end
    end

    // Port monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_en) rd_cycles <= rd_cycles + 1;
            if (wr_en) begin
                bufm[wr_sel][wr_addr] <= wr_data;
                if (wr_data[15:0] == 16'h0 && wr_data[23:16] < 32) begin
                    first_sel[wr_data[23:16]]  <= int'(wr_sel);
                    first_addr[wr_data[23:16]] <= int'(wr_addr);
                end
            end
            if (rdy_valid) begin
                hi_cycles <= hi_cycles + 1;
                if (n_ev < 16) begin
                    ev_idx[n_ev] <= int'(rdy_idx);
                    ev_cnt[n_ev] <= int'(rdy_count);
                end
                n_ev <= n_ev + 1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input int n, input bit auto_rel);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dma_done = rel_pend;
            rel_pend = auto_rel && rdy_valid;
        end
        @(negedge clk);
        dma_done = 1'b0;
        rel_pend = 1'b0;
    endtask

    task automatic push(input int len);
        rec_len[n_push] = len;
        n_push++;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic release_now();
        @(negedge clk); dma_done = 1'b1;
        @(negedge clk); dma_done = 1'b0;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int rd_before;
        for (int i = 0; i < 32; i++) begin
            rec_len[i] = 0; first_sel[i] = -1; first_addr[i] = -1;
        end
        repeat (3) @(negedge clk);
        check("R10 rd_en in reset", int'(rd_en), 0);
        check("R10 wr_en in reset", int'(wr_en), 0);
        check("R10 rdy_valid in reset", int'(rdy_valid), 0);
        rst_n = 1'b1;

        // R6: ticks with an empty buffer never flush it.
        for (int i = 0; i < 8; i++) pulse_tick();
        run(5, 1'b0);
        check("R6 no event on empty buffer", n_ev, 0);

        // Table walk: exact fit, full swap, overflow by one word (R2, R3, R4).
        for (int i = 0; i < 7; i++) push(int'(TBL[i][15:8]));
        run(150, 1'b1);
        for (int i = 0; i < 7; i++) begin
            check($sformatf("R2 table rec %0d buffer", i), first_sel[i], int'(TBL[i][7]));
            check($sformatf("R2 table rec %0d address", i), first_addr[i], int'(TBL[i][4:0]));
        end
        check("R10 first buffer filled is 0", first_sel[0], 0);
        check("R2 exact fit last word", int'(bufm[0][15]), int'(32'h5A02_0004));
        check("R4 event count", n_ev, 3);
        check("R4 event0 index", ev_idx[0], 0);
        check("R4 event0 count full", ev_cnt[0], BW);
        check("R1 event1 index", ev_idx[1], 1);
        check("R4 event1 count full", ev_cnt[1], BW);
        check("R3 no-fit event index", ev_idx[2], 0);
        check("R3 no-fit event count", ev_cnt[2], 7);
        check("R3 held record at address 0", first_addr[6], 0);

        // R5: timer flush only after TL ticks.
        for (int i = 0; i < TL - 1; i++) pulse_tick();
        run(10, 1'b0);
        check("R5 no flush before limit", n_ev, 3);
        pulse_tick();
        run(10, 1'b0);
        check("R5 flush at limit", n_ev, 4);
        check("R5 flush index", ev_idx[3], 1);
        check("R5 flush count", ev_cnt[3], 10);

        // R8: capacity swap while buffer 1 is still held.
        push(8); push(8);
        run(60, 1'b0);
        check("R8 no swap while held", n_ev, 4);
        push(5);
        rd_before = rd_cycles;
        run(30, 1'b0);
        check("R8 reads stalled", rd_cycles, rd_before);
        check("R8 still no event", n_ev, 4);
        release_now();
        run(30, 1'b0);
        check("R8 swap after release", n_ev, 5);
        check("R8 swap event index", ev_idx[4], 0);
        check("R8 swap event count", ev_cnt[4], BW);
        check("R8 first record placement", first_sel[9], 1);
        check("R8 overrun bit in status", int'(bufm[1][2]), int'(32'h5A09_0002 | OVR));
        check("R8 stalled record not lost", int'(bufm[1][4]), int'(32'h5A09_0004));
        push(5);
        run(30, 1'b0);
        check("R8 later record unmarked", int'(bufm[1][7]), int'(32'h5A0A_0002));

        // R9: release in the same cycle as the full-buffer swap.
        push(6);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (wr_en && wr_addr == AW'(BW - 1)) break;
        end
        release_now();
        push(4);
        run(30, 1'b0);
        check("R9 swap event seen", n_ev, 6);
        check("R9 swap event index", ev_idx[5], 1);
        check("R9 swap event count", ev_cnt[5], BW);
        check("R9 next record in buffer 0", first_sel[12], 0);
        check("R9 no overrun bit", int'(bufm[0][2]), int'(32'h5A0C_0002));

        check("R7 one high cycle per event", hi_cycles, n_ev);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule